// File: doc/BRIEF.md
# Repeater Port Isolation Monitor

This block watches one port of a multiport baseband repeater and decides when that port must be cut off from the others. It takes a microsecond tick and four per-port indications: receive activity, collision, false carrier (a start-of-stream delimiter that did not decode) and valid packet. From these it keeps three independent isolation causes. The first is a link-unstable state raised by repeated false carriers. The second is a partition for runs of collisions. The third is a jabber cut-off for receive activity that never ends. Each cause has its own recovery rule. A false carrier also raises a short request to jam every other port.

Every timeout is counted in microsecond ticks and set by a parameter. One instance serves one port. A repeater places one instance per port and combines the jam requests at the repeater core. The block only observes: it does not forward data and does not decode line symbols.

Top module: `port_isolation_monitor`

## Requirements
- R1: After reset, `partitioned`, `linkUnstable` and `jamOthers` are all low.
- R2: Each rising edge of `falseCarrier` raises `jamOthers` from the next clock. It drops after JAM_US ticks, or on the clock after `falseCarrier` goes low, whichever comes first.
- R3: The FC_LIMIT-th rising edge of `falseCarrier` (counted since reset or since the last link-unstable clear) sets `linkUnstable`, and with it `partitioned`.
- R4: `linkUnstable` clears on the tick that makes the idle time exceed QUIET_US ticks. Idle means `rxActive` and `falseCarrier` are both low.
- R5: A one-cycle `validPacket` pulse clears `linkUnstable` when at least IDLE_GAP_US idle ticks came before it. With a shorter idle gap the pulse has no effect.
- R6: Clearing `linkUnstable` resets the false-carrier count, so FC_LIMIT new events are needed to set it again.
- R7: A burst is a period of continuous `rxActive`. A burst during which `rxCollision` was high counts as a collision. When a burst ends and the run of consecutive collision bursts exceeds COL_LIMIT, the collision partition sets.
- R8: A burst that ends with no collision resets the consecutive-collision run to zero.
- R9: The collision partition clears once a single burst has stayed active for more than COL_CLEAR_US ticks with no collision in it. A collision anywhere in the burst blocks the clear.
- R10: `rxActive` held for more than JABBER_US ticks sets the jabber partition. It clears on the clock after `rxActive` falls.
- R11: `partitioned` is the OR of the three causes. Recovery of one cause never clears another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| usTick | input | 1 | One-cycle pulse per microsecond |
| rxActive | input | 1 | Receive activity on the port |
| rxCollision | input | 1 | Collision seen on the port |
| falseCarrier | input | 1 | False-carrier event in progress (level) |
| validPacket | input | 1 | One-cycle pulse at the start of a valid packet |
| partitioned | output | 1 | Port isolated for any cause |
| linkUnstable | output | 1 | False-carrier isolation cause |
| jamOthers | output | 1 | Request to jam all other ports |

## Verification
The bench builds the block with FC_LIMIT=2, JAM_US=3, QUIET_US=6, IDLE_GAP_US=4, COL_LIMIT=3, COL_CLEAR_US=2 and JABBER_US=5. With a tick every second clock, these small values let the bench sweep every burst length across the jabber threshold. They also allow every idle gap from zero to beyond the valid-packet limit, and every position in a collision run up to the partition point, all within a few hundred cycles. At each step the expected flag comes from the threshold arithmetic alone.

// File: rtl/isolation_pkg.sv
package isolation_pkg;

  // Strobes from the control decisions to the counters.
  typedef struct packed {
    logic fcInc;
    logic fcClr;
    logic jamLoad;
    logic jamRun;
    logic colInc;
    logic colClr;
  } ctlStrobe_t;

  // Edge and threshold results from the counters.
  typedef struct packed {
    logic fcRise;
    logic fcNear;
    logic fcLow;
    logic jamExpire;
    logic quietHit;
    logic gapMet;
    logic burstEndCol;
    logic burstEndClean;
    logic colNear;
    logic cleanHit;
    logic jabHit;
    logic active;
  } dpStatus_t;

endpackage

// File: rtl/isolation_dp.sv
module isolation_dp
  import isolation_pkg::*;
#(
  parameter int unsigned FC_LIMIT     = 2,
  parameter int unsigned JAM_US       = 5,
  parameter int unsigned QUIET_US     = 331,
  parameter int unsigned IDLE_GAP_US  = 640,
  parameter int unsigned COL_LIMIT    = 60,
  parameter int unsigned COL_CLEAR_US = 5,
  parameter int unsigned JABBER_US    = 400
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       usTick,
  input  logic       rxActive,
  input  logic       rxCollision,
  input  logic       falseCarrier,
  input  ctlStrobe_t strobe,
  output dpStatus_t  status
);

  localparam int unsigned IDLE_CAP = ((QUIET_US > IDLE_GAP_US) ? QUIET_US : IDLE_GAP_US) + 1;
  localparam int unsigned FC_W     = $clog2(FC_LIMIT + 1);
  localparam int unsigned JAM_W    = $clog2(JAM_US + 1);
  localparam int unsigned IDLE_W   = $clog2(IDLE_CAP + 1);
  localparam int unsigned COL_W    = $clog2(COL_LIMIT + 2);
  localparam int unsigned CLEAN_W  = $clog2(COL_CLEAR_US + 1);
  localparam int unsigned JAB_W    = $clog2(JABBER_US + 1);

  logic               prevAct, prevFc, hadCol;
  logic [FC_W-1:0]    fcCount;
  logic [JAM_W-1:0]   jamTimer;
  logic [IDLE_W-1:0]  idleTimer;
  logic [COL_W-1:0]   colCount;
  logic [CLEAN_W-1:0] cleanTimer;
  logic [JAB_W-1:0]   actTimer;

  logic lineIdle, actFall, cleanOk, jamExpire;

  assign lineIdle  = ~rxActive & ~falseCarrier;
  assign actFall   = prevAct & ~rxActive;
  assign cleanOk   = rxActive & ~rxCollision & ~hadCol;
  assign jamExpire = usTick & strobe.jamRun & (jamTimer == JAM_W'(JAM_US - 1));

  // Edge history and in-burst collision memory
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevAct <= 1'b0;
      prevFc  <= 1'b0;
      hadCol  <= 1'b0;
    end else begin
      prevAct <= rxActive;
      prevFc  <= falseCarrier;
      hadCol  <= rxActive ? (hadCol | rxCollision) : 1'b0;
    end
  end

  // False-carrier event counter
  always_ff @(posedge clk) begin
    if (!rstN)                                          fcCount <= '0;
    else if (strobe.fcClr)                              fcCount <= '0;
    else if (strobe.fcInc && fcCount != FC_W'(FC_LIMIT)) fcCount <= fcCount + 1'b1;
  end

  // Jam duration timer
  always_ff @(posedge clk) begin
    if (!rstN)                                       jamTimer <= '0;
    else if (strobe.jamLoad)                         jamTimer <= '0;
    else if (strobe.jamRun && usTick && !jamExpire)  jamTimer <= jamTimer + 1'b1;
  end

  // Idle-line timer
  always_ff @(posedge clk) begin
    if (!rstN)                                       idleTimer <= '0;
    else if (!lineIdle)                              idleTimer <= '0;
    else if (usTick && idleTimer != IDLE_W'(IDLE_CAP)) idleTimer <= idleTimer + 1'b1;
  end

  // Consecutive collision-burst counter
  always_ff @(posedge clk) begin
    if (!rstN)                                             colCount <= '0;
    else if (strobe.colClr)                                colCount <= '0;
    else if (strobe.colInc && colCount != COL_W'(COL_LIMIT + 1)) colCount <= colCount + 1'b1;
  end

  // Collision-free activity timer
  always_ff @(posedge clk) begin
    if (!rstN)                                            cleanTimer <= '0;
    else if (!cleanOk)                                    cleanTimer <= '0;
    else if (usTick && cleanTimer != CLEAN_W'(COL_CLEAR_US)) cleanTimer <= cleanTimer + 1'b1;
  end

  // Continuous activity timer
  always_ff @(posedge clk) begin
    if (!rstN)                                       actTimer <= '0;
    else if (!rxActive)                              actTimer <= '0;
    else if (usTick && actTimer != JAB_W'(JABBER_US)) actTimer <= actTimer + 1'b1;
  end

  always_comb begin
    status.fcRise        = falseCarrier & ~prevFc;
    status.fcNear        = fcCount >= FC_W'(FC_LIMIT - 1);
    status.fcLow         = ~falseCarrier;
    status.jamExpire     = jamExpire;
    status.quietHit      = usTick & lineIdle & (idleTimer == IDLE_W'(QUIET_US));
    status.gapMet        = idleTimer >= IDLE_W'(IDLE_GAP_US);
    status.burstEndCol   = actFall & hadCol;
    status.burstEndClean = actFall & ~hadCol;
    status.colNear       = colCount >= COL_W'(COL_LIMIT);
    status.cleanHit      = usTick & cleanOk & (cleanTimer == CLEAN_W'(COL_CLEAR_US));
    status.jabHit        = usTick & rxActive & (actTimer == JAB_W'(JABBER_US));
    status.active        = rxActive;
  end

  // R2
  jam_timer_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    jamTimer <= JAM_W'(JAM_US - 1));

  // R7
  col_count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    colCount <= COL_W'(COL_LIMIT + 1));

endmodule

// File: rtl/isolation_ctl.sv
module isolation_ctl
  import isolation_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       validPacket,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic       unstableFlag,
  output logic       jamFlag,
  output logic       colFlag,
  output logic       jabFlag
);

  logic unstableSet, unstableClr, jamClr, colSet, colClr;

  always_comb begin
    unstableSet = status.fcRise & status.fcNear;
    unstableClr = unstableFlag & ~status.fcRise &
                  (status.quietHit | (validPacket & status.gapMet));
    jamClr      = jamFlag & (status.fcLow | status.jamExpire);
    colSet      = status.burstEndCol & status.colNear;
    colClr      = colFlag & status.cleanHit;

    strobe.fcInc   = status.fcRise;
    strobe.fcClr   = unstableClr;
    strobe.jamLoad = status.fcRise;
    strobe.jamRun  = jamFlag;
    strobe.colInc  = status.burstEndCol;
    strobe.colClr  = status.burstEndClean | colClr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unstableFlag <= 1'b0;
      jamFlag      <= 1'b0;
      colFlag      <= 1'b0;
      jabFlag      <= 1'b0;
    end else begin
      if (unstableSet)      unstableFlag <= 1'b1;
      else if (unstableClr) unstableFlag <= 1'b0;

      if (status.fcRise)    jamFlag <= 1'b1;
      else if (jamClr)      jamFlag <= 1'b0;

      if (colSet)           colFlag <= 1'b1;
      else if (colClr)      colFlag <= 1'b0;

      if (status.jabHit)      jabFlag <= 1'b1;
      else if (!status.active) jabFlag <= 1'b0;
    end
  end

  // R9
  col_clear_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(colFlag) |-> $past(status.active));

endmodule

// File: rtl/port_isolation_monitor.sv
module port_isolation_monitor
  import isolation_pkg::*;
#(
  parameter int unsigned FC_LIMIT     = 2,
  parameter int unsigned JAM_US       = 5,
  parameter int unsigned QUIET_US     = 331,
  parameter int unsigned IDLE_GAP_US  = 640,
  parameter int unsigned COL_LIMIT    = 60,
  parameter int unsigned COL_CLEAR_US = 5,
  parameter int unsigned JABBER_US    = 400
) (
  input  logic clk,
  input  logic rstN,
  input  logic usTick,
  input  logic rxActive,
  input  logic rxCollision,
  input  logic falseCarrier,
  input  logic validPacket,
  output logic partitioned,
  output logic linkUnstable,
  output logic jamOthers
);

  ctlStrobe_t strobe;
  dpStatus_t  status;
  logic       colPart, jabPart;

  isolation_dp #(
    .FC_LIMIT(FC_LIMIT), .JAM_US(JAM_US), .QUIET_US(QUIET_US),
    .IDLE_GAP_US(IDLE_GAP_US), .COL_LIMIT(COL_LIMIT),
    .COL_CLEAR_US(COL_CLEAR_US), .JABBER_US(JABBER_US)
  ) dp_i (
    .clk(clk), .rstN(rstN), .usTick(usTick), .rxActive(rxActive),
    .rxCollision(rxCollision), .falseCarrier(falseCarrier),
    .strobe(strobe), .status(status)
  );

  isolation_ctl ctl_i (
    .clk(clk), .rstN(rstN), .validPacket(validPacket), .status(status),
    .strobe(strobe), .unstableFlag(linkUnstable), .jamFlag(jamOthers),
    .colFlag(colPart), .jabFlag(jabPart)
  );

  assign partitioned = linkUnstable | colPart | jabPart;

  // R2
  jam_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(jamOthers) |-> $past(falseCarrier));

  // R3
  unstable_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linkUnstable) |-> $past(falseCarrier));

  // R10
  jab_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxActive) |=> !jabPart);

endmodule

// File: tb/port_isolation_monitor_tb.sv
`timescale 1ns/1ps
module port_isolation_monitor_tb_top;

  localparam int FC_LIMIT     = 2;
  localparam int JAM_US       = 3;
  localparam int QUIET_US     = 6;
  localparam int IDLE_GAP_US  = 4;
  localparam int COL_LIMIT    = 3;
  localparam int COL_CLEAR_US = 2;
  localparam int JABBER_US    = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic usTick = 1'b0, rxActive = 1'b0, rxCollision = 1'b0;
  logic falseCarrier = 1'b0, validPacket = 1'b0;
  logic partitioned, linkUnstable, jamOthers;
  int   nChecks = 0, nFail = 0;

  always #2.5 clk = ~clk;

  port_isolation_monitor #(
    .FC_LIMIT(FC_LIMIT), .JAM_US(JAM_US), .QUIET_US(QUIET_US),
    .IDLE_GAP_US(IDLE_GAP_US), .COL_LIMIT(COL_LIMIT),
    .COL_CLEAR_US(COL_CLEAR_US), .JABBER_US(JABBER_US)
  ) dut_i (
    .clk(clk), .rstN(rstN), .usTick(usTick), .rxActive(rxActive),
    .rxCollision(rxCollision), .falseCarrier(falseCarrier),
    .validPacket(validPacket), .partitioned(partitioned),
    .linkUnstable(linkUnstable), .jamOthers(jamOthers)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tickStep(input int n);
    repeat (n) begin
      usTick = 1'b1; @(negedge clk);
      usTick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic fcEvent();
    falseCarrier = 1'b1; step(1);
    falseCarrier = 1'b0; step(1);
  endtask

  task automatic colBurst();
    rxActive = 1'b1; rxCollision = 1'b1; step(1);
    rxActive = 1'b0; rxCollision = 1'b0; step(1);
  endtask

  task automatic cleanBurst();
    rxActive = 1'b1; step(1);
    rxActive = 1'b0; step(1);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    step(4);
    // R1 reset state
    chk("R1 partitioned", partitioned, 1'b0);
    chk("R1 linkUnstable", linkUnstable, 1'b0);
    chk("R1 jamOthers", jamOthers, 1'b0);
    rstN = 1'b1;
    step(2);
    chk("R1 after release", partitioned, 1'b0);

    // R10 jabber: sweep burst lengths across the threshold
    for (int len = 1; len <= JABBER_US + 3; len++) begin
      rxActive = 1'b1;
      tickStep(len);
      chk("R10 jabber set", partitioned, len > JABBER_US);
      rxActive = 1'b0;
      step(1);
      chk("R10 jabber release", partitioned, 1'b0);
      step(1);
    end

    // R7 collision run, R8 clean burst resets the run
    for (int k = 1; k <= COL_LIMIT; k++) begin
      colBurst();
      chk("R7 run below limit", partitioned, 1'b0);
    end
    cleanBurst();
    for (int k = 1; k <= COL_LIMIT + 1; k++) begin
      colBurst();
      chk("R8 run restarted", partitioned, k > COL_LIMIT);
    end

    // R9 collision inside the burst blocks the clear
    rxActive = 1'b1; rxCollision = 1'b1; step(1);
    rxCollision = 1'b0;
    tickStep(COL_CLEAR_US + 2);
    chk("R9 blocked by collision", partitioned, 1'b1);
    rxActive = 1'b0; step(1);
    chk("R9 still partitioned", partitioned, 1'b1);
    // R9 clean activity clears once it exceeds COL_CLEAR_US ticks
    rxActive = 1'b1;
    tickStep(COL_CLEAR_US);
    chk("R9 at threshold", partitioned, 1'b1);
    tickStep(1);
    chk("R9 cleared", partitioned, 1'b0);
    rxActive = 1'b0; step(2);

    // R2 jam ends with the event, R3 first event below limit
    chk("R2 idle no jam", jamOthers, 1'b0);
    falseCarrier = 1'b1; step(1);
    chk("R2 jam raised", jamOthers, 1'b1);
    chk("R3 first event", linkUnstable, 1'b0);
    falseCarrier = 1'b0; step(1);
    chk("R2 jam follows event end", jamOthers, 1'b0);
    // R3 second event; R2 jam times out while event persists
    falseCarrier = 1'b1; step(1);
    chk("R3 unstable set", linkUnstable, 1'b1);
    chk("R3 partitioned", partitioned, 1'b1);
    tickStep(JAM_US - 1);
    chk("R2 jam held", jamOthers, 1'b1);
    tickStep(1);
    chk("R2 jam timeout", jamOthers, 1'b0);
    falseCarrier = 1'b0; step(1);

    // R4 quiet-time clear
    tickStep(QUIET_US);
    chk("R4 at threshold", linkUnstable, 1'b1);
    tickStep(1);
    chk("R4 cleared", linkUnstable, 1'b0);
    chk("R4 partition off", partitioned, 1'b0);

    // R6 count restarted after clear
    fcEvent();
    chk("R6 one event after clear", linkUnstable, 1'b0);
    fcEvent();
    chk("R6 second event", linkUnstable, 1'b1);
    tickStep(QUIET_US + 1);
    chk("R6 cleared again", linkUnstable, 0);

    // R5 sweep of idle gap before a valid packet
    for (int gap = 0; gap <= IDLE_GAP_US + 1; gap++) begin
      fcEvent(); fcEvent();
      chk("R5 unstable before gap", linkUnstable, 1'b1);
      tickStep(gap);
      rxActive = 1'b1; validPacket = 1'b1; step(1);
      validPacket = 1'b0;
      chk("R5 valid packet gap", linkUnstable, gap < IDLE_GAP_US);
      rxActive = 1'b0; step(1);
      if (gap < IDLE_GAP_US) begin
        tickStep(QUIET_US + 1);
        chk("R5 quiet recovery", linkUnstable, 1'b0);
      end
    end

    // R11 jabber release leaves link-unstable in place
    fcEvent(); fcEvent();
    rxActive = 1'b1;
    tickStep(JABBER_US + 1);
    chk("R11 both causes", partitioned, 1'b1);
    rxActive = 1'b0; step(1);
    chk("R11 unstable holds partition", partitioned, 1'b1);
    chk("R11 unstable flag", linkUnstable, 1'b1);
    tickStep(QUIET_US + 1);
    chk("R11 all clear", partitioned, 1'b0);

    // R11 link-unstable recovery leaves collision partition in place
    for (int k = 1; k <= COL_LIMIT + 1; k++) colBurst();
    fcEvent(); fcEvent();
    tickStep(QUIET_US + 1);
    chk("R11 unstable recovered", linkUnstable, 1'b0);
    chk("R11 collision holds partition", partitioned, 1'b1);
    rxActive = 1'b1;
    tickStep(COL_CLEAR_US + 1);
    chk("R11 collision recovered", partitioned, 1'b0);
    rxActive = 1'b0; step(2);

    summary();
    $finish;
  end

endmodule